// File: doc/BRIEF.md
# Conditional Execution Flag Evaluator

This block decides whether an instruction may execute. It takes a 32-bit status word holding four arithmetic flags and an instruction word that carries a 4-bit condition code. For full-width instructions the code sits in the top nibble of the word. For short conditional branches the code sits in bits 11:8, and a select input picks which of the two positions applies. Both positions feed one shared decoder. The decoder covers single-flag tests and the unsigned and signed magnitude comparisons.

The verdict is registered. One cycle after a request is presented with its strobe, a result strobe rises together with the pass/fail bit. Between requests the last verdict stays on the output. Flag generation, instruction decode beyond the condition field, and the branch itself are handled elsewhere.

Top module: `cond_gate`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `out_valid` and `out_pass` are both 0.
- R2: `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high, so latency is one clock.
- R3: With `is_short` = 0, the condition code is `insn_word[31:28]`, and the other instruction bits have no effect on the verdict.
- R4: With `is_short` = 1, the condition code is `insn_word[11:8]`, and bits 31:28 have no effect on the verdict.
- R5: The flags are read from fixed positions: negative at status bit 31, zero at bit 30, carry at bit 29, overflow at bit 28.
- R6: Codes 0/1 pass when zero is set/clear. Codes 2/3 pass when carry is set/clear. Codes 4/5 pass when negative is set/clear. Codes 6/7 pass when overflow is set/clear.
- R7: Code 8 passes when carry is set and zero is clear. Code 9 passes when carry is clear or zero is set.
- R8: Code 10 passes when negative equals overflow. Code 11 passes when they differ.
- R9: Code 12 passes when zero is clear and negative equals overflow. Code 13 passes when zero is set or negative differs from overflow.
- R10: Codes 14 and 15 pass for every flag combination.
- R11: In a cycle after `in_valid` was low, `out_pass` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| is_short | input | 1 | 1 selects the short-branch code position (bits 11:8) |
| status_word | input | 32 | Status word carrying the flags |
| insn_word | input | 32 | Instruction word carrying the condition code |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_pass | output | 1 | Registered verdict, 1 means execute |

## Verification
The assertions assume that `in_valid` stays low while reset is held. The bench drives every input on the falling clock edge and keeps the strobe at 0 across reset. Each assertion relates a request to the verdict one cycle later, so it also assumes that the status and instruction words are sampled only in strobed cycles. To keep R3 and R4 honest, the stimulus places the bitwise complement of the code in the code position that is not selected.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;

   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
      logic ovf;
   } flag_set_t;

   // Upper three bits of the condition code select a test; bit 0 inverts it.
   typedef enum logic [2:0] {
      SEL_ZERO      = 3'd0,
      SEL_CARRY     = 3'd1,
      SEL_NEG       = 3'd2,
      SEL_OVF       = 3'd3,
      SEL_ABOVE     = 3'd4,
      SEL_SIGNED_GE = 3'd5,
      SEL_SIGNED_GT = 3'd6,
      SEL_ALWAYS    = 3'd7
   } test_sel_e;

endpackage

// File: rtl/cond_flag_split.sv
module cond_flag_split
   import cond_gate_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int NEG_BIT = 31,
   parameter int ZERO_BIT = 30,
   parameter int CARRY_BIT = 29,
   parameter int OVF_BIT = 28
) (
   input  logic [WORD_W-1:0] status_word,
   output flag_set_t         flags
);

   always_comb begin
      flags.neg   = status_word[NEG_BIT];
      flags.zero  = status_word[ZERO_BIT];
      flags.carry = status_word[CARRY_BIT];
      flags.ovf   = status_word[OVF_BIT];
   end

   // Only the four flag bits are read.
   logic unused_status;
   assign unused_status = ^status_word;

endmodule

// File: rtl/cond_field_pick.sv
module cond_field_pick #(
   parameter int WORD_W = 32,
   parameter int CODE_W = 4,
   parameter int WIDE_LSB = 28,
   parameter int SHORT_LSB = 8,
   parameter bit SHORT_EN = 1'b1
) (
   input  logic [WORD_W-1:0] insn_word,
   input  logic              is_short,
   output logic [CODE_W-1:0] code
);

   logic [CODE_W-1:0] wide_code;
   assign wide_code = insn_word[WIDE_LSB +: CODE_W];

   generate
      if (SHORT_EN) begin : g_two_pos
         logic [CODE_W-1:0] short_code;
         assign short_code = insn_word[SHORT_LSB +: CODE_W];
         assign code = is_short ? short_code : wide_code;
      end else begin : g_one_pos
         logic unused_sel;
         assign unused_sel = is_short;
         assign code = wide_code;
      end
   endgenerate

   logic unused_insn;
   assign unused_insn = ^insn_word;

endmodule

// File: rtl/cond_table_eval.sv
module cond_table_eval
   import cond_gate_pkg::*;
#(
   parameter int CODE_W = 4,
   parameter bit RESERVED_PASS = 1'b1
) (
   input  flag_set_t         flags,
   input  logic [CODE_W-1:0] code,
   output logic              pass
);

   localparam logic [CODE_W-1:0] RESERVED_CODE = {CODE_W{1'b1}};

   test_sel_e sel;
   logic      base;
   logic      signs_agree;

   assign sel         = test_sel_e'(code[CODE_W-1:1]);
   assign signs_agree = (flags.neg == flags.ovf);

   always_comb begin
      unique case (sel)
         SEL_ZERO:      base = flags.zero;
         SEL_CARRY:     base = flags.carry;
         SEL_NEG:       base = flags.neg;
         SEL_OVF:       base = flags.ovf;
         SEL_ABOVE:     base = flags.carry & ~flags.zero;
         SEL_SIGNED_GE: base = signs_agree;
         SEL_SIGNED_GT: base = ~flags.zero & signs_agree;
         SEL_ALWAYS:    base = 1'b1;
         default:       base = 1'b1;
      endcase
   end

   generate
      if (RESERVED_PASS) begin : g_res_pass
         assign pass = (sel == SEL_ALWAYS) ? 1'b1 : (base ^ code[0]);
      end else begin : g_res_fail
         assign pass = (code == RESERVED_CODE) ? 1'b0 : (base ^ code[0]);
      end
   endgenerate

endmodule

// File: rtl/cond_result_reg.sv
module cond_result_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic pass_d,
   output logic out_valid,
   output logic out_pass
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pass  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_pass <= pass_d;
      end
   end

endmodule

// File: rtl/cond_gate.sv
module cond_gate
   import cond_gate_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CODE_W = 4,
   parameter int WIDE_LSB = 28,
   parameter int SHORT_LSB = 8,
   parameter bit SHORT_EN = 1'b1,
   parameter bit RESERVED_PASS = 1'b1,
   parameter int NEG_BIT = 31,
   parameter int ZERO_BIT = 30,
   parameter int CARRY_BIT = 29,
   parameter int OVF_BIT = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              is_short,
   input  logic [WORD_W-1:0] status_word,
   input  logic [WORD_W-1:0] insn_word,
   output logic              out_valid,
   output logic              out_pass
);

   localparam int WIDE_TOP  = WIDE_LSB + CODE_W;
   localparam int SHORT_TOP = SHORT_LSB + CODE_W;

   generate
      if (CODE_W != 4) begin : g_bad_code_w
         $error("cond_gate: decoder table expects a 4-bit code");
      end
      if (WIDE_TOP > WORD_W) begin : g_bad_wide
         $error("cond_gate: wide code field exceeds word");
      end
      if (SHORT_EN && (SHORT_TOP > WORD_W)) begin : g_bad_short
         $error("cond_gate: short code field exceeds word");
      end
      if (NEG_BIT >= WORD_W || ZERO_BIT >= WORD_W ||
          CARRY_BIT >= WORD_W || OVF_BIT >= WORD_W) begin : g_bad_flag
         $error("cond_gate: flag position outside status word");
      end
   endgenerate

   flag_set_t         flags;
   logic [CODE_W-1:0] code;
   logic              pass_d;

   cond_flag_split #(
      .WORD_W(WORD_W), .NEG_BIT(NEG_BIT), .ZERO_BIT(ZERO_BIT),
      .CARRY_BIT(CARRY_BIT), .OVF_BIT(OVF_BIT)
   ) u_flags (
      .status_word(status_word),
      .flags(flags)
   );

   cond_field_pick #(
      .WORD_W(WORD_W), .CODE_W(CODE_W), .WIDE_LSB(WIDE_LSB),
      .SHORT_LSB(SHORT_LSB), .SHORT_EN(SHORT_EN)
   ) u_pick (
      .insn_word(insn_word),
      .is_short(is_short),
      .code(code)
   );

   cond_table_eval #(
      .CODE_W(CODE_W), .RESERVED_PASS(RESERVED_PASS)
   ) u_eval (
      .flags(flags),
      .code(code),
      .pass(pass_d)
   );

   cond_result_reg u_reg (
      .clk(clk),
      .rst_n(rst_n),
      .in_valid(in_valid),
      .pass_d(pass_d),
      .out_valid(out_valid),
      .out_pass(out_pass)
   );

endmodule

// File: rtl/cond_gate_checker.sv
module cond_gate_checker #(
   parameter int WORD_W = 32,
   parameter int CODE_W = 4,
   parameter int WIDE_LSB = 28,
   parameter int SHORT_LSB = 8,
   parameter int ZERO_BIT = 30,
   parameter int CARRY_BIT = 29
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              is_short,
   input logic [WORD_W-1:0] status_word,
   input logic [WORD_W-1:0] insn_word,
   input logic              out_valid,
   input logic              out_pass
);

   // R2: result strobe follows request strobe by one cycle
   p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R11: verdict held between requests
   p_hold_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_pass));

   // R3 / R6: wide position, code 0 tracks the zero flag
   p_wide_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_short && insn_word[WIDE_LSB +: CODE_W] == 4'd0)
      |=> (out_pass == $past(status_word[ZERO_BIT])));

   // R4 / R6: short position, code 3 is carry clear
   p_short_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_short && insn_word[SHORT_LSB +: CODE_W] == 4'd3)
      |=> (out_pass == !$past(status_word[CARRY_BIT])));

   // R10: unconditional code in the wide position
   p_always_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_short && insn_word[WIDE_LSB +: CODE_W] == 4'd14)
      |=> out_pass);

   // R1: reset state
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r1: assert (!out_valid && !out_pass);
      end
   end

endmodule

bind cond_gate cond_gate_checker #(
   .WORD_W(WORD_W), .CODE_W(CODE_W), .WIDE_LSB(WIDE_LSB),
   .SHORT_LSB(SHORT_LSB), .ZERO_BIT(ZERO_BIT), .CARRY_BIT(CARRY_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_short(is_short),
   .status_word(status_word), .insn_word(insn_word),
   .out_valid(out_valid), .out_pass(out_pass)
);

// File: tb/sim_cond_gate.sv
module sim_cond_gate;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        is_short = 1'b0;
   logic [31:0] status_word = '0;
   logic [31:0] insn_word = '0;
   logic        out_valid;
   logic        out_pass;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_gate u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_short(is_short),
      .status_word(status_word), .insn_word(insn_word),
      .out_valid(out_valid), .out_pass(out_pass)
   );

   // Reference from the requirement table; flags = {N,Z,C,V} at status 31..28.
   function automatic logic ref_pass(input logic [3:0] f, input logic [3:0] code);
      logic n, z, c, v;
      {n, z, c, v} = f;
      case (code)
         4'd0:  ref_pass = z;
         4'd1:  ref_pass = !z;
         4'd2:  ref_pass = c;
         4'd3:  ref_pass = !c;
         4'd4:  ref_pass = n;
         4'd5:  ref_pass = !n;
         4'd6:  ref_pass = v;
         4'd7:  ref_pass = !v;
         4'd8:  ref_pass = c && !z;
         4'd9:  ref_pass = !c || z;
         4'd10: ref_pass = (n == v);
         4'd11: ref_pass = (n != v);
         4'd12: ref_pass = !z && (n == v);
         4'd13: ref_pass = z || (n != v);
         default: ref_pass = 1'b1;
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // Apply one request; check strobe and verdict one clock later.
   task automatic apply(input string req, input logic [3:0] f, input logic [3:0] code,
                        input logic sh);
      logic [31:0] w;
      w = 32'h05A3_C65F ^ {4'h0, 28'h1234_567};
      if (sh) begin
         w[11:8]  = code;
         w[31:28] = ~code;
      end else begin
         w[31:28] = code;
         w[11:8]  = ~code;
      end
      @(negedge clk);
      in_valid    = 1'b1;
      is_short    = sh;
      insn_word   = w;
      status_word = {f, 28'h9E3_7B1A};
      @(negedge clk);
      in_valid    = 1'b0;
      status_word = ~status_word;
      insn_word   = ~insn_word;
      check("R2", out_valid, 1'b1, "strobe after request");
      check(req, out_pass, ref_pass(f, code), $sformatf("code %0d flags %b short %b", code, f, sh));
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1", out_valid, 1'b0, "valid in reset");
      check("R1", out_pass, 1'b0, "pass in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", out_valid, 1'b0, "valid after release");
      check("R1", out_pass, 1'b0, "pass after release");
   endtask

   task automatic t_single_flags;
      for (int code = 0; code < 8; code++)
         for (int f = 0; f < 16; f++)
            apply("R6", f[3:0], code[3:0], 1'b0);
   endtask

   task automatic t_flag_positions;
      // R5: each flag alone, probed through its own code
      apply("R5", 4'b1000, 4'd4, 1'b0);
      apply("R5", 4'b0100, 4'd0, 1'b0);
      apply("R5", 4'b0010, 4'd2, 1'b0);
      apply("R5", 4'b0001, 4'd6, 1'b0);
      apply("R5", 4'b0111, 4'd4, 1'b0);
      apply("R5", 4'b1011, 4'd0, 1'b0);
   endtask

   task automatic t_unsigned;
      for (int code = 8; code < 10; code++)
         for (int f = 0; f < 16; f++)
            apply("R7", f[3:0], code[3:0], 1'b0);
   endtask

   task automatic t_signed_ge;
      for (int code = 10; code < 12; code++)
         for (int f = 0; f < 16; f++)
            apply("R8", f[3:0], code[3:0], 1'b0);
   endtask

   task automatic t_signed_gt;
      for (int code = 12; code < 14; code++)
         for (int f = 0; f < 16; f++)
            apply("R9", f[3:0], code[3:0], 1'b0);
   endtask

   task automatic t_always;
      for (int code = 14; code < 16; code++)
         for (int f = 0; f < 16; f++)
            apply("R10", f[3:0], code[3:0], 1'b0);
   endtask

   task automatic t_wide_field;
      for (int code = 0; code < 16; code++)
         apply("R3", 4'b0101, code[3:0], 1'b0);
   endtask

   task automatic t_short_field;
      for (int code = 0; code < 16; code++)
         for (int f = 0; f < 16; f += 5)
            apply("R4", f[3:0], code[3:0], 1'b1);
   endtask

   task automatic t_hold;
      // verdict 1, then idle cycles with flags that would fail
      apply("R11", 4'b0100, 4'd0, 1'b0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R11", out_pass, 1'b1, "held high while idle");
         check("R2", out_valid, 1'b0, "no strobe while idle");
      end
      apply("R11", 4'b0000, 4'd0, 1'b0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         status_word = 32'h4000_0000;
         check("R11", out_pass, 1'b0, "held low while idle");
      end
   endtask

   task automatic t_back_to_back;
      // consecutive requests, each verdict lands one clock later
      @(negedge clk);
      in_valid = 1'b1; is_short = 1'b0;
      status_word = 32'h4000_0000; insn_word = 32'h0000_0000;
      @(negedge clk);
      check("R2", out_valid, 1'b1, "first of pair");
      check("R6", out_pass, 1'b1, "first of pair");
      status_word = 32'h4000_0000; insn_word = 32'h1000_0000;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2", out_valid, 1'b1, "second of pair");
      check("R6", out_pass, 1'b0, "second of pair");
      @(negedge clk);
      check("R2", out_valid, 1'b0, "strobe drops");
   endtask

   initial begin
      t_reset();
      t_flag_positions();
      t_single_flags();
      t_unsigned();
      t_signed_ge();
      t_signed_gt();
      t_always();
      t_wide_field();
      t_short_field();
      t_hold();
      t_back_to_back();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule